// File: doc/BRIEF.md
# Periodic Interval Timer with Interrupt Gating

This block produces a regular interrupt from a programmable reload value and, alongside it, keeps a free-running time counter that software can read at any moment. Software first writes a reload value, then selects the load operation to copy that value into the down-counter, then selects the run operation to start it. Each time the count runs out, the counter refills itself from the reload register and raises a pending interrupt flag. That flag passes through an enable mask to the `irq` output and is cleared by writing a one to an acknowledge address.

The current count can be read back, so software can tell how far the present period has progressed. At a 100 MHz base clock, a reload value of 1,000,000 gives a 100 Hz tick. A second rate setting advances the counter only once every `SLOW_DIV` clocks. The reload value may be changed while the counter runs. The change is picked up at the next refill and does not alter the count already in progress. All access goes through one flat word-wide register port. Reads are combinational, and writes take effect at the clock edge on which `wr_en` is high.

Top module: `tmr_periodic`

## Requirements
- R1: After reset, every address except 7 reads zero and `irq` is low. Address 7 reads zero in the first cycle after reset is released.
- R2: Address 0 is the reload value, which can be read back and written. Writing it while counting leaves the current count on its normal course, and the new value is loaded at the next refill.
- R3: The control word sits at address 1, with the operation code in bits 1:0. Code 1 (load) copies the reload value into the count at the edge of the write and keeps it there while the code stays selected.
- R4: Code 2 (run) lowers the count by one on each tick, and the edge that writes code 2 is itself a tick.
- R5: Codes 0 and 3 freeze the count at its present value.
- R6: A tick that finds the count at 1 or 0 refills it from the reload value and sets the pending flag on the same edge. A reload value D greater than 0 therefore gives a period of D ticks, with the count read as D minus (ticks mod D). A reload value of 0 keeps the count at 0 and flags every tick.
- R7: Control bit 2 selects the rate. With 0, every clock is a tick. With 1, a tick comes once every `SLOW_DIV` clocks, and the phase restarts whenever load is selected.
- R8: Address 3 bit 0 is the enable mask. Address 4 bit 0 reads the pending flag. Address 5 bit 0 reads the flag ANDed with the mask, and `irq` follows that same value.
- R9: Writing address 6 with bit 0 set clears the pending flag. A refill on the same edge wins over the clear. Writing bit 0 as zero has no effect.
- R10: Address 7 is a free-running time count that rises by one on every clock and wraps modulo 2^`TIME_W`. Writes to it are ignored.
- R11: Address 2 reads the current count. Writes to addresses 2, 4 and 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Pending flag gated by the enable mask |

## Verification
The countdown is run with several randomly drawn reload values, including 1 and 0, and sampled at random step lengths. This tells a correct period of D ticks apart from off-by-one refills and from a missing decrement on the run edge. Directed sequences place an acknowledge exactly on a refill edge, rewrite the reload value mid-period, and switch to the slow rate from a fresh load. These separate priority mistakes, early adoption of a new reload value, and a prescaler phase that is not restarted. Hold codes, writes to read-only addresses and a cleared mask are checked by reading back the state they could have disturbed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned ADR_W = 3;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_RUN  = 2'd2,
        OP_HALT = 2'd3
    } tmr_op_e;

    typedef struct packed {
        logic    slow;
        tmr_op_e op;
    } tmr_ctrl_t;

    localparam logic [ADR_W-1:0] A_RELOAD = 3'd0;
    localparam logic [ADR_W-1:0] A_CTRL   = 3'd1;
    localparam logic [ADR_W-1:0] A_COUNT  = 3'd2;
    localparam logic [ADR_W-1:0] A_MASK   = 3'd3;
    localparam logic [ADR_W-1:0] A_RAW    = 3'd4;
    localparam logic [ADR_W-1:0] A_GATED  = 3'd5;
    localparam logic [ADR_W-1:0] A_ACK    = 3'd6;
    localparam logic [ADR_W-1:0] A_TIME   = 3'd7;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  logic slow_sel,
    output logic tick
);
    localparam int unsigned PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(SLOW_DIV - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        tick    = 1'b0;
        if (clear) begin
            phase_d = '0;
        end else if (advance) begin
            if (!slow_sel) begin
                tick = 1'b1;
            end else begin
                tick    = (phase_q == LAST);
                phase_d = tick ? '0 : phase_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        expire  = 1'b0;
        if (load) begin
            count_d = reload_val;
        end else if (tick) begin
            if (count_q <= CNT_W'(1)) begin
                count_d = reload_val;
                expire  = 1'b1;
            end else begin
                count_d = count_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    input  logic mask_we,
    input  logic mask_val,
    output logic raw,
    output logic mask,
    output logic gated
);
    typedef struct packed {
        logic raw;
        logic mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set)       st_d.raw = 1'b1;
        else if (ack)  st_d.raw = 1'b0;
        if (mask_we)   st_d.mask = mask_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw   = st_q.raw;
    assign mask  = st_q.mask;
    assign gated = st_q.raw & st_q.mask;
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
    parameter int unsigned TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);
    logic [TIME_W-1:0] now_d, now_q;

    always_comb now_d = now_q + TIME_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_d;
    end

    assign now = now_q;
endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned TIME_W   = 32,
    parameter int unsigned SLOW_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        tmr_ctrl_t        ctrl;
    } regs_t;

    regs_t            regs_d, regs_q;
    tmr_ctrl_t        ctrl_eff;
    logic             ctrl_we, load_op, run_op, hold_op;
    logic             tick, expire, raw, mask, gated;
    logic [CNT_W-1:0] count;
    logic [TIME_W-1:0] time_q;

    always_comb begin
        regs_d  = regs_q;
        ctrl_we = wr_en && (addr == A_CTRL);
        if (wr_en && (addr == A_RELOAD)) regs_d.reload = wdata[CNT_W-1:0];
        if (ctrl_we)                     regs_d.ctrl   = tmr_ctrl_t'(wdata[2:0]);
        ctrl_eff = ctrl_we ? tmr_ctrl_t'(wdata[2:0]) : regs_q.ctrl;
        load_op  = (ctrl_eff.op == OP_LOAD);
        run_op   = (ctrl_eff.op == OP_RUN);
        hold_op  = !load_op && !run_op;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    tmr_prescale #(.SLOW_DIV(SLOW_DIV)) i_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load_op),
        .advance  (run_op),
        .slow_sel (ctrl_eff.slow),
        .tick     (tick)
    );

    tmr_downcount #(.CNT_W(CNT_W)) i_downcount (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_op),
        .tick       (tick),
        .reload_val (regs_q.reload),
        .count      (count),
        .expire     (expire)
    );

    tmr_irq i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (expire),
        .ack      (wr_en && (addr == A_ACK) && wdata[0]),
        .mask_we  (wr_en && (addr == A_MASK)),
        .mask_val (wdata[0]),
        .raw      (raw),
        .mask     (mask),
        .gated    (gated)
    );

    tmr_timebase #(.TIME_W(TIME_W)) i_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (time_q)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            A_RELOAD: rdata = BUS_W'(regs_q.reload);
            A_CTRL:   rdata = BUS_W'(regs_q.ctrl);
            A_COUNT:  rdata = BUS_W'(count);
            A_MASK:   rdata = BUS_W'(mask);
            A_RAW:    rdata = BUS_W'(raw);
            A_GATED:  rdata = BUS_W'(gated);
            A_TIME:   rdata = BUS_W'(time_q);
            default:  rdata = '0;
        endcase
    end

    assign irq = gated;
endmodule

// File: rtl/tmr_periodic_chk.sv
module tmr_periodic_chk
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned TIME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADR_W-1:0]  addr,
    input logic [BUS_W-1:0]  wdata,
    input logic [CNT_W-1:0]  reload,
    input logic [CNT_W-1:0]  count,
    input logic              tick,
    input logic              load_op,
    input logic              hold_op,
    input logic              expire,
    input logic              raw,
    input logic [TIME_W-1:0] time_q
);
    // R3: load copies the reload value
    p_load_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_op |=> count == $past(reload));

    // R4: a tick above the terminal value lowers the count by one
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_op && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));

    // R5: hold codes freeze the count
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_op |=> $stable(count));

    // R6: terminal tick refills and flags
    p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_op && count <= CNT_W'(1)) |=> (count == $past(reload)) && raw);

    // R9: acknowledge clears unless a refill lands on the same edge
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ACK && wdata[0] && !expire) |=> !raw);

    // R10: time count advances by exactly one per clock
    p_time_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (time_q - $past(time_q)) == TIME_W'(1));
endmodule

bind tmr_periodic tmr_periodic_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .reload  (regs_q.reload),
    .count   (count),
    .tick    (tick),
    .load_op (load_op),
    .hold_op (hold_op),
    .expire  (expire),
    .raw     (raw),
    .time_q  (time_q)
);

// File: tb/test_tmr_periodic.sv
module test_tmr_periodic;
    localparam int unsigned SLOW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    int t = 0;

    tmr_periodic #(.CNT_W(32), .TIME_W(32), .SLOW_DIV(SLOW)) i_tmr_periodic (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] exp_count(input logic [31:0] d, input int ticks);
        if (d == 0) return 32'd0;
        return d - (32'(ticks) % d);
    endfunction

    function automatic logic exp_raw(input logic [31:0] d, input int ticks);
        return (d == 0) ? (ticks >= 1) : (32'(ticks) >= d);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        total++;
        fails++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v, v2, c, d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd7, v); check("R1 time", v, 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v); check("R1 reg", v, 0);
        end
        check("R1 irq", {31'd0, irq}, 0);

        // R10: time count
        rd(3'd7, v); idle(37); rd(3'd7, v2); check("R10 step", v2 - v, 37);
        wr(3'd7, 32'hFFFF_0000); rd(3'd7, v); check("R10 write ignored", v, v2 + 1);

        // R3, R4, R6: random reload values
        for (int k = 0; k < 8; k++) begin
            d = (k == 0) ? 32'd1 : 32'($urandom_range(2, 25));
            wr(3'd0, d);
            wr(3'd1, 32'd1);
            rd(3'd2, v); check("R3 load", v, d);
            idle(3);
            rd(3'd2, v); check("R3 load held", v, d);
            wr(3'd6, 32'd1);
            rd(3'd4, v); check("R9 cleared", v, 0);
            wr(3'd1, 32'd2); t = 1;
            rd(3'd2, v); check("R4 run edge", v, exp_count(d, t));
            for (int s = 0; s < 10; s++) begin
                int st = int'($urandom_range(1, 7));
                idle(st); t += st;
                rd(3'd2, v); check("R4/R6 count", v, exp_count(d, t));
                rd(3'd4, v); check("R6 flag", v, 32'(exp_raw(d, t)));
            end
        end

        // R8: mask and gated view (raw set from above)
        wr(3'd1, 32'd0);
        rd(3'd4, v); check("R8 raw", v, 1);
        rd(3'd5, v); check("R8 gated masked off", v, 0);
        check("R8 irq masked off", {31'd0, irq}, 0);
        wr(3'd3, 32'd1);
        rd(3'd3, v); check("R8 mask", v, 1);
        rd(3'd5, v); check("R8 gated", v, 1);
        check("R8 irq", {31'd0, irq}, 1);

        // R5: hold codes
        rd(3'd2, c); idle(5); rd(3'd2, v); check("R5 code0", v, c);
        wr(3'd1, 32'd3); idle(4); rd(3'd2, v); check("R5 code3", v, c);

        // R9: acknowledge
        wr(3'd6, 32'd0); rd(3'd4, v); check("R9 zero ignored", v, 1);
        wr(3'd6, 32'd1); rd(3'd4, v); check("R9 clear", v, 0);
        check("R8 irq after ack", {31'd0, irq}, 0);
        wr(3'd0, 32'd6); wr(3'd1, 32'd1);
        wr(3'd1, 32'd2); t = 1;
        idle(4); t += 4;
        wr(3'd6, 32'd1); t += 1;
        rd(3'd4, v); check("R9 refill wins", v, 1);
        rd(3'd2, v); check("R6 refill value", v, 6);

        // R2: reload rewrite mid-period
        wr(3'd0, 32'd13);
        rd(3'd2, v); check("R2 count undisturbed", v, 5);
        rd(3'd0, v); check("R2 readback", v, 13);
        idle(4); rd(3'd2, v); check("R2 old course", v, 1);
        idle(1); rd(3'd2, v); check("R2 new at refill", v, 13);

        // R7: slow rate
        wr(3'd1, 32'd0); wr(3'd0, 32'd5);
        wr(3'd1, 32'd5);
        wr(3'd1, 32'd6);
        rd(3'd2, v); check("R7 m1", v, exp_count(5, 1 / SLOW));
        idle(2); rd(3'd2, v); check("R7 m3", v, exp_count(5, 3 / SLOW));
        idle(1); rd(3'd2, v); check("R7 m4", v, exp_count(5, 4 / SLOW));
        idle(8); rd(3'd2, v); check("R7 m12", v, exp_count(5, 12 / SLOW));
        idle(8); rd(3'd2, v); check("R7 m20", v, exp_count(5, 20 / SLOW));

        // R6: reload value zero
        wr(3'd1, 32'd0); wr(3'd0, 32'd0); wr(3'd1, 32'd1);
        rd(3'd2, v); check("R6 zero load", v, 0);
        wr(3'd6, 32'd1); rd(3'd4, v); check("R6 zero cleared", v, 0);
        wr(3'd1, 32'd2);
        rd(3'd4, v); check("R6 zero flags", v, 1);
        rd(3'd2, v); check("R6 zero count", v, 0);

        // R11: read-only addresses
        wr(3'd0, 32'd9); wr(3'd1, 32'd1); wr(3'd1, 32'd0);
        wr(3'd6, 32'd1);
        rd(3'd2, c); check("R11 count read", c, 9);
        wr(3'd2, 32'h1234); rd(3'd2, v); check("R11 count write ignored", v, c);
        wr(3'd4, 32'd1); rd(3'd4, v); check("R11 raw write ignored", v, 0);
        wr(3'd5, 32'd1); rd(3'd5, v); check("R11 gated write ignored", v, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule